// File: doc/BRIEF.md
# Symbol-Timing Drift Clock-Offset Estimator

This block sits after an OFDM receiver's symbol-timing estimator and reads the FFT-window start position found for each symbol. The position is an integer sample index in the range 0 to P-1, with P = 2560 by default (a 2048-point FFT plus a 512-sample cyclic prefix at 30.72 MHz). When the sampling clocks of the transmitter and the receiver differ, the window start creeps later or earlier from one symbol to the next. The block turns that creep into a measure of the clock offset.

It takes the step between consecutive positions. A step that crosses the 0 / P-1 seam is unwrapped, so that a window sliding past the symbol edge reads as a small move. The block keeps the N most recent steps in a ring and maintains their sum. Each time a new step enters a full ring, it issues two registered estimates with a one-cycle valid pulse. The first is the clock offset in Hz, where one sample of drift per symbol corresponds to 12 kHz. The second is the drift expressed as fractional delay per input sample, for the delay accumulator of a downstream fractional resampler.

N is a power of two, so the averaging divide is a shift. A later-moving window means the receiver clock runs fast, and both estimates are then positive.

Top module: `sco_drift_estimator`

## Requirements
- R1: After reset, `est_valid` is 0 and `est_hz` and `est_slope` are 0.
- R2: The first accepted position after reset forms no step. Each later accepted position forms a step against the previous accepted one. Position values presented while `pos_valid` is 0 are ignored.
- R3: The raw step is current minus previous. A raw step above P/2 has P subtracted, and a raw step below -P/2 has P added. Steps of exactly +P/2 or -P/2 are kept as they are. With P = 2560, a raw step of 1281 gives -1279, and a raw step of -2559 gives +1.
- R4: `est_hz` equals floor(12000 * S / N), where S is the sum of the N most recent steps. It is a two's-complement value, HZ_W = 32 bits wide.
- R5: Until N steps have been collected, `est_valid` stays 0 and both estimates stay 0. From then on, every accepted position produces a one-cycle `est_valid` pulse in the clock cycle after it is sampled, carrying the updated estimates.
- R6: The signs of both estimates follow the drift. Later-moving windows give positive values, earlier-moving windows give negative values, and no drift gives zero.
- R7: `est_slope` equals floor(S * floor(2^32 / P) / N). This is the per-symbol drift divided by P, as a two's-complement number with 32 fractional bits, SLOPE_W = 48 bits wide.
- R8: The average slides. Each new step displaces the oldest of the N held steps.
- R9: Between valid pulses, `est_hz` and `est_slope` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_valid | input | 1 | A window position is presented this cycle |
| pos | input | POS_W (12) | FFT-window start index, 0 to P-1 |
| est_valid | output | 1 | One-cycle strobe: new estimates on the outputs |
| est_hz | output | HZ_W (32) | Signed clock-offset estimate in Hz |
| est_slope | output | SLOPE_W (48) | Signed fractional delay per sample, 32 fractional bits |

## Verification
The bound checker watches four things on every cycle:
- every unwrapped step stays within plus or minus P/2;
- no estimate or strobe appears before the ring has filled;
- a strobe only ever follows an accepted step;
- the estimates hold whenever no position arrives, and the two estimates always agree in sign.

The exact arithmetic can only be shown by the bench's scenarios, which compare both estimates against a behavioural queue model on every clock. That arithmetic covers the wrap seam, the ±P/2 boundary, floor rounding of negative sums, and the sliding of old steps out of the window.

// File: rtl/sco_pkg.sv
package sco_pkg;
  typedef logic signed [63:0] wide_t;

  // Fold a position step back into [-P/2, +P/2] across the symbol seam.
  function automatic wide_t unwrap_step(wide_t cur, wide_t prv, wide_t sym_len);
    wide_t d;
    d = cur - prv;
    if (d > (sym_len >>> 1))
      d = d - sym_len;
    else if (d < -(sym_len >>> 1))
      d = d + sym_len;
    return d;
  endfunction

  // One sample of drift per symbol equals 12 kHz; divide by 2^log2n (floor).
  function automatic wide_t hz_scale(wide_t sum, int unsigned log2n);
    return (sum * 64'sd12000) >>> log2n;
  endfunction

  // Drift per symbol divided by the symbol length, frac fractional bits (floor).
  function automatic wide_t slope_scale(wide_t sum, int unsigned log2n,
                                        int unsigned frac, wide_t sym_len);
    wide_t k;
    k = (64'sd1 <<< frac) / sym_len;
    return (sum * k) >>> log2n;
  endfunction
endpackage

// File: rtl/sco_step_unwrap.sv
module sco_step_unwrap
  import sco_pkg::*;
#(
  parameter int SYM_LEN = 2560,
  parameter int POS_W   = 12,
  parameter int DIFF_W  = POS_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pos_valid,
  input  logic [POS_W-1:0]         pos,
  output logic                     step_valid,
  output logic signed [DIFF_W-1:0] step
);
  logic [POS_W-1:0] prev_q;
  logic             have_prev_q;

  assign step       = DIFF_W'(unwrap_step(wide_t'(pos), wide_t'(prev_q), wide_t'(SYM_LEN)));
  assign step_valid = pos_valid && have_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (pos_valid) begin
      prev_q      <= pos;
      have_prev_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sco_step_window.sv
module sco_step_window #(
  parameter int DIFF_W   = 13,
  parameter int AVG_LOG2 = 3,
  parameter int SUM_W    = DIFF_W + AVG_LOG2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_valid,
  input  logic signed [DIFF_W-1:0] step,
  output logic signed [SUM_W-1:0]  sum_next,
  output logic                     win_ready,
  output logic                     win_full
);
  localparam int DEPTH = 1 << AVG_LOG2;

  logic signed [DIFF_W-1:0] ring_q [DEPTH];
  logic [AVG_LOG2-1:0]      wr_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic                     full_q;
  logic                     wr_last;

  assign wr_last   = (wr_q == AVG_LOG2'(DEPTH - 1));
  assign sum_next  = sum_q + SUM_W'(step) - SUM_W'(ring_q[wr_q]);
  assign win_ready = step_valid && (full_q || wr_last);
  assign win_full  = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      wr_q   <= '0;
      full_q <= 1'b0;
    end else if (step_valid) begin
      sum_q  <= sum_next;
      wr_q   <= wr_q + 1'b1;
      full_q <= full_q | wr_last;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ring
    always_ff @(posedge clk) begin
      if (!rst_n)
        ring_q[g] <= '0;
      else if (step_valid && wr_q == AVG_LOG2'(g))
        ring_q[g] <= step;
    end
  end
endmodule

// File: rtl/sco_drift_estimator.sv
module sco_drift_estimator
  import sco_pkg::*;
#(
  parameter int SYM_LEN  = 2560,
  parameter int POS_W    = 12,
  parameter int AVG_LOG2 = 3,
  parameter int HZ_W     = 32,
  parameter int FRAC_W   = 32,
  parameter int SLOPE_W  = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pos_valid,
  input  logic [POS_W-1:0]          pos,
  output logic                      est_valid,
  output logic signed [HZ_W-1:0]    est_hz,
  output logic signed [SLOPE_W-1:0] est_slope
);
  localparam int DIFF_W = POS_W + 1;
  localparam int SUM_W  = DIFF_W + AVG_LOG2;

  logic                     step_valid;
  logic signed [DIFF_W-1:0] step;
  logic signed [SUM_W-1:0]  sum_next;
  logic                     win_ready;
  logic                     win_full;
  logic signed [HZ_W-1:0]    hz_next;
  logic signed [SLOPE_W-1:0] slope_next;

  sco_step_unwrap #(.SYM_LEN(SYM_LEN), .POS_W(POS_W), .DIFF_W(DIFF_W)) unwrap_i (
    .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid), .pos(pos),
    .step_valid(step_valid), .step(step)
  );

  sco_step_window #(.DIFF_W(DIFF_W), .AVG_LOG2(AVG_LOG2), .SUM_W(SUM_W)) window_i (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step(step),
    .sum_next(sum_next), .win_ready(win_ready), .win_full(win_full)
  );

  assign hz_next    = HZ_W'(hz_scale(wide_t'(sum_next), AVG_LOG2));
  assign slope_next = SLOPE_W'(slope_scale(wide_t'(sum_next), AVG_LOG2, FRAC_W,
                                           wide_t'(SYM_LEN)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      est_valid <= 1'b0;
      est_hz    <= '0;
      est_slope <= '0;
    end else begin
      est_valid <= win_ready;
      if (win_ready) begin
        est_hz    <= hz_next;
        est_slope <= slope_next;
      end
    end
  end
endmodule

// File: rtl/sco_drift_checker.sv
module sco_drift_checker #(
  parameter int SYM_LEN = 2560,
  parameter int DIFF_W  = 13,
  parameter int HZ_W    = 32,
  parameter int SLOPE_W = 48
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pos_valid,
  input logic                      step_valid,
  input logic signed [DIFF_W-1:0]  step,
  input logic                      win_full,
  input logic                      est_valid,
  input logic signed [HZ_W-1:0]    est_hz,
  input logic signed [SLOPE_W-1:0] est_slope
);
  localparam int HALF = SYM_LEN / 2;

  assert_step_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (int'(step) <= HALF && int'(step) >= -HALF));

  assert_quiet_until_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_full |-> (!est_valid && est_hz == '0 && est_slope == '0));

  assert_strobe_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(step_valid));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |=> ($stable(est_hz) && $stable(est_slope)));

  assert_sign_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (((est_hz > 0) == (est_slope > 0)) && ((est_hz < 0) == (est_slope < 0))));
endmodule

bind sco_drift_estimator sco_drift_checker #(
  .SYM_LEN(SYM_LEN), .DIFF_W(DIFF_W), .HZ_W(HZ_W), .SLOPE_W(SLOPE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid), .step_valid(step_valid),
  .step(step), .win_full(win_full), .est_valid(est_valid),
  .est_hz(est_hz), .est_slope(est_slope)
);

// File: tb/sco_drift_estimator_tb.sv
module sco_drift_estimator_tb_top;
  localparam int P    = 2560;
  localparam int NAVG = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pos_valid = 1'b0;
  logic [11:0]        pos = '0;
  logic               est_valid;
  logic signed [31:0] est_hz;
  logic signed [47:0] est_slope;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sco_drift_estimator dut_i (
    .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid), .pos(pos),
    .est_valid(est_valid), .est_hz(est_hz), .est_slope(est_slope)
  );

  // Behavioural reference model
  longint steps[$];
  longint prev_pos;
  bit     have_prev;
  longint m_d, m_s;
  bit     e_valid;
  longint e_hz, e_slope;
  longint kslope;

  function automatic longint fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  initial kslope = (longint'(1) << 32) / P;

  always @(posedge clk) begin
    if (!rst_n) begin
      steps.delete();
      have_prev = 0; prev_pos = 0;
      e_valid = 0; e_hz = 0; e_slope = 0;
    end else begin
      e_valid = 0;
      if (pos_valid) begin
        if (have_prev) begin
          m_d = longint'(pos) - prev_pos;
          if (2 * m_d > P) m_d = m_d - P;
          if (2 * m_d < -P) m_d = m_d + P;
          steps.push_back(m_d);
          if (steps.size() > NAVG) void'(steps.pop_front());
          if (steps.size() == NAVG) begin
            m_s = 0;
            foreach (steps[i]) m_s = m_s + steps[i];
            e_valid = 1;
            e_hz    = fdiv(m_s * 12000, NAVG);
            e_slope = fdiv(m_s * kslope, NAVG);
          end
        end
        prev_pos = longint'(pos);
        have_prev = 1;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 est_valid vs model", longint'(est_valid), longint'(e_valid));
      chk("R4 est_hz vs model", longint'(est_hz), e_hz);
      chk("R7 est_slope vs model", longint'(est_slope), e_slope);
    end
  end

  task automatic send(int p);
    @(negedge clk);
    pos_valid = 1'b1;
    pos = 12'(p);
    @(negedge clk);
    pos_valid = 1'b0;
    pos = 12'hABC;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int p;
    int seed;
    repeat (3) @(negedge clk);
    chk("R1 reset est_valid", longint'(est_valid), 0);
    chk("R1 reset est_hz", longint'(est_hz), 0);
    chk("R1 reset est_slope", longint'(est_slope), 0);
    rst_n = 1'b1;

    // R5/R2: first position forms no step; seven steps keep outputs quiet
    p = 100;
    send(p);
    for (int i = 0; i < 7; i++) begin p = p + 1; send(p); end
    chk("R5 not valid before window full", longint'(est_valid), 0);
    chk("R5 hz zero before window full", longint'(est_hz), 0);
    p = p + 1; send(p);
    chk("R4 hz for +1 per symbol", longint'(est_hz), 12000);
    chk("R7 slope for +1 per symbol", longint'(est_slope), 1677721);
    chk("R6 positive drift gives positive hz", longint'(est_hz > 0), 1);

    // R9/R2: garbage while pos_valid low is ignored, outputs hold
    repeat (5) @(negedge clk);
    chk("R9 hz held while idle", longint'(est_hz), 12000);
    p = p + 1; send(p);
    chk("R2 idle position value ignored", longint'(est_hz), 12000);

    // R3: crossing the seam 2559 -> 0 reads as +1
    p = 2556;
    send(p);
    for (int i = 0; i < 8; i++) begin p = (p + 1) % P; send(p); end
    chk("R3 seam crossing unwrapped", longint'(est_hz), 12000);

    // R3 boundary: seven zero steps then +1280 kept
    do_reset();
    send(1000);
    for (int i = 0; i < 7; i++) send(1000);
    send(2280);
    chk("R3 step of +P/2 kept", longint'(est_hz), 1920000);
    do_reset();
    send(500);
    for (int i = 0; i < 7; i++) send(500);
    send(1781);
    chk("R3 step of 1281 unwrapped to -1279", longint'(est_hz), -1918500);

    // R7 floor rounding on small sums
    do_reset();
    send(10);
    for (int i = 0; i < 7; i++) send(10);
    send(11);
    chk("R7 slope floor for sum +1", longint'(est_slope), 209715);
    send(11); send(11); send(11); send(11); send(11); send(11); send(11);
    send(10);
    chk("R7 slope floor for sum -1", longint'(est_slope), -209716);

    // R6 negative drift, then R8 sliding out
    p = 10;
    for (int i = 0; i < 8; i++) begin p = (p + P - 1) % P; send(p); end
    chk("R6 earlier drift hz", longint'(est_hz), -12000);
    chk("R6 earlier drift slope", longint'(est_slope), -1677721);
    for (int i = 0; i < 4; i++) send(p);
    chk("R8 half window replaced", longint'(est_hz), -6000);
    for (int i = 0; i < 4; i++) send(p);
    chk("R8 window fully replaced", longint'(est_hz), 0);
    chk("R6 zero drift slope", longint'(est_slope), 0);

    // Mixed pseudo-random drift with back-to-back positions
    seed = 7;
    p = 1200;
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      p = (p + P + (seed % 7) - 3) % P;
      if ((seed & 8) != 0) p = (p + 1279) % P;
      @(negedge clk);
      pos_valid = ((seed & 16) == 0) ? 1'b1 : 1'b0;
      pos = 12'(p);
    end
    @(negedge clk);
    pos_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule